// File: doc/BRIEF.md
# Dual-Mode Serial Control Register Port

This block is a write-only serial port that loads 16-bit control words into a small register file. Each word has two fields. The upper seven bits (bit 15 down to bit 9) name a register. The lower nine bits (bit 8 down to bit 0) are the value to store. Three registers hold configuration fields for the rest of the chip. Writing to address 7 does not store anything. Instead it raises a software-reset pulse for the neighbouring logic.

The port runs in one of two wire protocols, and the level of the chip-select pin just after reset picks which one.

- **Three-wire mode:** plain shifting. Data is clocked in on each rising serial-clock edge, and a rising chip-select edge commits the most recent 16 bits.
- **Two-wire mode:** an addressed bus slave.
  - It recognises start and stop conditions and matches a 7-bit device identity with a write direction bit.
  - It then takes two data bytes. The first byte holds bit 15 to bit 8 of the word and the second holds bit 7 to bit 0.
  - It acknowledges the address and each data byte by asserting a pull-low enable for the ninth clock.

All serial pins are synchronised into the system clock domain and handled as sampled edges. The whole block therefore runs on one clock.

Top module: `ser_ctrl_slave`

## Requirements
- R1: After reset, register 0 reads 0x003, register 1 reads 0x00A, register 2 reads 0x003, and the software-reset output is low.
- R2: The chip-select level in the first clock after reset selects the protocol: high selects three-wire and low selects two-wire. Traffic in the other protocol changes no register, and in three-wire mode the pull-low output is never asserted.
- R3: In three-wire mode each rising serial-clock edge shifts in one data bit, MSB first. A rising chip-select edge commits only the last 16 bits shifted in.
- R4: In a control word, bits 15..9 are the register address and bits 8..0 are the stored value. In two-wire mode, bit 8 arrives as the last bit of the first data byte.
- R5: In two-wire mode, a start is a falling data edge while the clock is high, and a stop is a rising data edge while the clock is high. After a start, the device byte 0x34 (identity 0011010, direction bit 0) and the two data bytes are each acknowledged with the pull-low output during the ninth clock. The word is then written.
- R6: A device byte with another identity, or with the direction bit set to 1, gets no acknowledge. The data bytes that follow also get no acknowledge and cause no write.
- R7: A stop or a new start in the middle of a two-wire transfer abandons the partial word without writing. After a new start, the port begins again with the device byte.
- R8: Writes to addresses other than 0, 1, 2 and 7 are accepted (and acknowledged in two-wire mode) but change no register.
- R9: A write to address 7 raises the software-reset output for exactly SRST_CYCLES clock cycles, whatever its data. It changes no register.
- R10: While software reset is high, a write to any other address lowers it in the cycle after that write takes effect. That write is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin |
| sda_i | input | 1 | Serial data pin (wired bus level in two-wire mode) |
| csb_i | input | 1 | Chip select; its level after reset selects the protocol |
| sda_pull_o | output | 1 | Pull-low enable for the data pin (acknowledge) |
| ctl0_o | output | 9 | Register 0 contents |
| ctl1_o | output | 9 | Register 1 contents |
| ctl2_o | output | 9 | Register 2 contents |
| soft_rst_o | output | 1 | Software-reset pulse |

## Verification
The bench builds the block with SRST_CYCLES set to 400 and every other parameter at its default. With that setting, a whole second three-wire word can be shifted in while the software-reset pulse from an address-7 write is still high, so the early-release path of R10 can be reached through the pins. The same bench still checks the full-length pulse of R9 against the 400-cycle window. The default two-stage synchroniser and device identity 0011010 are kept, so the acknowledge timing is checked with the serial half-period eight times longer than the clock.

// File: rtl/scs_pkg.sv
package scs_pkg;
    localparam int CW_ADDR = 7;
    localparam int CW_DATA = 9;
    localparam int CW_WORD = CW_ADDR + CW_DATA;

    typedef struct packed {
        logic               valid;
        logic [CW_ADDR-1:0] addr;
        logic [CW_DATA-1:0] data;
    } ctrl_wr_t;

    typedef enum logic [2:0] {
        TW_IDLE,
        TW_RECV,
        TW_ACKSET,
        TW_ACK,
        TW_SKIP
    } tw_state_e;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '1;
        else         s_q <= s_d;
    end

    assign lvl_o  = s_q.pipe[STAGES-1];
    assign rise_o = lvl_o & ~s_q.prev;
    assign fall_o = ~lvl_o & s_q.prev;
endmodule

// File: rtl/scs_shift3.sv
module scs_shift3 import scs_pkg::*; (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  logic     clk_rise_i,
    input  logic     dat_i,
    input  logic     cs_rise_i,
    output ctrl_wr_t wr_o
);
    typedef struct packed {
        logic [CW_WORD-1:0] sh;
        ctrl_wr_t           wr;
    } sh3_st_t;

    sh3_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.wr = '0;
        if (en_i) begin
            if (clk_rise_i) begin
                s_d.sh = {s_q.sh[CW_WORD-2:0], dat_i};
            end
            if (cs_rise_i) begin
                s_d.wr.valid = 1'b1;
                s_d.wr.addr  = s_q.sh[CW_WORD-1:CW_DATA];
                s_d.wr.data  = s_q.sh[CW_DATA-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign wr_o = s_q.wr;
endmodule

// File: rtl/scs_twi.sv
module scs_twi import scs_pkg::*; #(
    parameter logic [6:0] DEV_ID = 7'b0011010
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  logic     scl_lvl_i,
    input  logic     scl_rise_i,
    input  logic     scl_fall_i,
    input  logic     sda_lvl_i,
    input  logic     sda_rise_i,
    input  logic     sda_fall_i,
    output ctrl_wr_t wr_o,
    output logic     pull_o
);
    typedef struct packed {
        tw_state_e  st;
        logic [2:0] bit_cnt;
        logic [1:0] byte_idx;
        logic [7:0] sh;
        logic [7:0] hi;
        logic       pull;
        ctrl_wr_t   wr;
    } tw_st_t;

    tw_st_t     s_d, s_q;
    logic [7:0] sh_n;

    always_comb begin
        s_d    = s_q;
        s_d.wr = '0;
        sh_n   = {s_q.sh[6:0], sda_lvl_i};
        if (!en_i) begin
            s_d.st   = TW_IDLE;
            s_d.pull = 1'b0;
        end else if (scl_lvl_i && sda_fall_i) begin
            s_d.st       = TW_RECV;
            s_d.bit_cnt  = '0;
            s_d.byte_idx = '0;
            s_d.pull     = 1'b0;
        end else if (scl_lvl_i && sda_rise_i) begin
            s_d.st   = TW_IDLE;
            s_d.pull = 1'b0;
        end else begin
            case (s_q.st)
                TW_RECV: begin
                    if (scl_rise_i) begin
                        s_d.sh      = sh_n;
                        s_d.bit_cnt = s_q.bit_cnt + 3'd1;
                        if (s_q.bit_cnt == 3'd7) begin
                            case (s_q.byte_idx)
                                2'd0: s_d.st = (sh_n == {DEV_ID, 1'b0}) ? TW_ACKSET : TW_SKIP;
                                2'd1: begin
                                    s_d.hi = sh_n;
                                    s_d.st = TW_ACKSET;
                                end
                                default: begin
                                    s_d.wr.valid = 1'b1;
                                    s_d.wr.addr  = s_q.hi[7:1];
                                    s_d.wr.data  = {s_q.hi[0], sh_n};
                                    s_d.st       = TW_ACKSET;
                                end
                            endcase
                        end
                    end
                end
                TW_ACKSET: begin
                    if (scl_fall_i) begin
                        s_d.pull = 1'b1;
                        s_d.st   = TW_ACK;
                    end
                end
                TW_ACK: begin
                    if (scl_fall_i) begin
                        s_d.pull = 1'b0;
                        if (s_q.byte_idx == 2'd2) begin
                            s_d.st = TW_SKIP;
                        end else begin
                            s_d.st       = TW_RECV;
                            s_d.byte_idx = s_q.byte_idx + 2'd1;
                            s_d.bit_cnt  = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= TW_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_o   = s_q.wr;
    assign pull_o = s_q.pull;
endmodule

// File: rtl/scs_regs.sv
module scs_regs import scs_pkg::*; #(
    parameter int                      NREG        = 3,
    parameter logic [NREG*CW_DATA-1:0] RST_VALS    = '0,
    parameter logic [CW_ADDR-1:0]      SRST_ADDR   = 7'd7,
    parameter int                      SRST_CYCLES = 4
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  ctrl_wr_t                       wr_i,
    output logic [NREG-1:0][CW_DATA-1:0]   regs_o,
    output logic                           srst_o
);
    localparam int CNT_W = $clog2(SRST_CYCLES + 1);

    typedef struct packed {
        logic [NREG-1:0][CW_DATA-1:0] regs;
        logic [CNT_W-1:0]             cnt;
    } rf_st_t;

    rf_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i.valid) begin
            if (wr_i.addr == SRST_ADDR) begin
                s_d.cnt = CNT_W'(SRST_CYCLES);
            end else begin
                s_d.cnt = '0;
                for (int i = 0; i < NREG; i++) begin
                    if (wr_i.addr == CW_ADDR'(i)) s_d.regs[i] = wr_i.data;
                end
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.regs <= RST_VALS;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs_o = s_q.regs;
    assign srst_o = (s_q.cnt != '0);
endmodule

// File: rtl/ser_ctrl_slave.sv
module ser_ctrl_slave import scs_pkg::*; #(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [6:0]         DEV_ID      = 7'b0011010,
    parameter int                 SRST_CYCLES = 4,
    parameter logic [CW_DATA-1:0] R0_RST      = 9'h003,
    parameter logic [CW_DATA-1:0] R1_RST      = 9'h00A,
    parameter logic [CW_DATA-1:0] R2_RST      = 9'h003
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               csb_i,
    output logic               sda_pull_o,
    output logic [CW_DATA-1:0] ctl0_o,
    output logic [CW_DATA-1:0] ctl1_o,
    output logic [CW_DATA-1:0] ctl2_o,
    output logic               soft_rst_o
);
    localparam int NREG = 3;

    typedef struct packed {
        logic done;
        logic three_wire;
    } strap_t;

    strap_t strap_d, strap_q;

    always_comb begin
        strap_d = strap_q;
        if (!strap_q.done) begin
            strap_d.done       = 1'b1;
            strap_d.three_wire = csb_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            strap_q.done       <= 1'b0;
            strap_q.three_wire <= 1'b1;
        end else begin
            strap_q <= strap_d;
        end
    end

    logic mode_3w, mode_2w;
    assign mode_3w = strap_q.done & strap_q.three_wire;
    assign mode_2w = strap_q.done & ~strap_q.three_wire;

    logic [2:0] pin_lvl, pin_rise, pin_fall;

    scs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({csb_i, sda_i, scl_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    logic unused_sync;
    assign unused_sync = ^{pin_lvl[2], pin_fall[2]};

    ctrl_wr_t wr3, wr2, wr_sel;
    logic     pull2;

    scs_shift3 u_shift3 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (mode_3w),
        .clk_rise_i (pin_rise[0]),
        .dat_i      (pin_lvl[1]),
        .cs_rise_i  (pin_rise[2]),
        .wr_o       (wr3)
    );

    scs_twi #(.DEV_ID(DEV_ID)) u_twi (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (mode_2w),
        .scl_lvl_i  (pin_lvl[0]),
        .scl_rise_i (pin_rise[0]),
        .scl_fall_i (pin_fall[0]),
        .sda_lvl_i  (pin_lvl[1]),
        .sda_rise_i (pin_rise[1]),
        .sda_fall_i (pin_fall[1]),
        .wr_o       (wr2),
        .pull_o     (pull2)
    );

    assign wr_sel     = mode_3w ? wr3 : wr2;
    assign sda_pull_o = pull2;

    logic [NREG-1:0][CW_DATA-1:0] regs;

    scs_regs #(
        .NREG        (NREG),
        .RST_VALS    ({R2_RST, R1_RST, R0_RST}),
        .SRST_ADDR   (7'd7),
        .SRST_CYCLES (SRST_CYCLES)
    ) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_sel),
        .regs_o (regs),
        .srst_o (soft_rst_o)
    );

    assign ctl0_o = regs[0];
    assign ctl1_o = regs[1];
    assign ctl2_o = regs[2];
endmodule

// File: rtl/scs_checker.sv
module scs_checker import scs_pkg::*; #(
    parameter int SRST_CYCLES = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               mode_3w,
    input ctrl_wr_t           wr,
    input logic               sda_pull_o,
    input logic [CW_DATA-1:0] ctl0_o,
    input logic [CW_DATA-1:0] ctl1_o,
    input logic [CW_DATA-1:0] ctl2_o,
    input logic               soft_rst_o
);
    int hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           hi_cnt <= 0;
        else if (wr.valid && wr.addr == 7'd7)  hi_cnt <= 0;
        else if (soft_rst_o)                   hi_cnt <= hi_cnt + 1;
        else                                   hi_cnt <= 0;
    end

    assert_pull_only_2w_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_3w |-> !sda_pull_o);

    assert_srst_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_rst_o) |-> $past(wr.valid && wr.addr == 7'd7));

    assert_srst_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_o |-> (hi_cnt < SRST_CYCLES));

    assert_early_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_o && wr.valid && wr.addr != 7'd7) |=> !soft_rst_o);

    assert_hold_regs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr.valid || (wr.addr > 7'd2)) |=> ($stable(ctl0_o) && $stable(ctl1_o) && $stable(ctl2_o)));
endmodule

bind ser_ctrl_slave scs_checker #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_3w    (mode_3w),
    .wr         (wr_sel),
    .sda_pull_o (sda_pull_o),
    .ctl0_o     (ctl0_o),
    .ctl1_o     (ctl1_o),
    .ctl2_o     (ctl2_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/test_ser_ctrl_slave.sv
module test_ser_ctrl_slave;
    localparam int H    = 8;
    localparam int SRST = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic csb = 1'b1;
    logic pull;
    logic sda_bus;
    logic [8:0] ctl0, ctl1, ctl2;
    logic soft_rst;

    int checks = 0;
    int errors = 0;
    int srst_hi = 0;
    logic a0, a1, a2;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~pull;

    ser_ctrl_slave #(.SRST_CYCLES(SRST)) i_ser_ctrl_slave (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .csb_i      (csb),
        .sda_pull_o (pull),
        .ctl0_o     (ctl0),
        .ctl1_o     (ctl1),
        .ctl2_o     (ctl2),
        .soft_rst_o (soft_rst)
    );

    always @(negedge clk) if (soft_rst) srst_hi++;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] word(input logic [6:0] a, input logic [8:0] d);
        return {a, d};
    endfunction

    task automatic do_reset(input logic csb_lvl);
        @(negedge clk);
        rst_n = 1'b0; csb = csb_lvl; scl = 1'b1; m_sda = 1'b1;
        wt(4);
        rst_n = 1'b1;
        wt(10);
    endtask

    task automatic w3_send(input logic [31:0] bits, input int n);
        csb = 1'b0;
        wt(H);
        for (int i = n - 1; i >= 0; i--) begin
            scl = 1'b0; m_sda = bits[i];
            wt(H);
            scl = 1'b1;
            wt(H);
        end
        wt(H);
        csb = 1'b1;
        wt(2 * H);
    endtask

    task automatic tw_start();
        m_sda = 1'b1; wt(H);
        scl = 1'b1;   wt(H);
        m_sda = 1'b0; wt(H);
        scl = 1'b0;   wt(H);
    endtask

    task automatic tw_stop();
        m_sda = 1'b0; wt(H);
        scl = 1'b1;   wt(H);
        m_sda = 1'b1; wt(2 * H);
    endtask

    task automatic tw_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            m_sda = b[i];
            wt(H);
            scl = 1'b1;
            wt(H);
            scl = 1'b0;
            wt(2);
        end
    endtask

    task automatic tw_byte(input logic [7:0] b, output logic ack);
        tw_bits(b, 8);
        m_sda = 1'b1;
        wt(H);
        scl = 1'b1;
        wt(H / 2);
        ack = (sda_bus == 1'b0);
        wt(H / 2);
        scl = 1'b0;
        wt(H);
    endtask

    task automatic tw_write(input logic [7:0] devb, input logic [15:0] w);
        tw_start();
        tw_byte(devb, a0);
        tw_byte(w[15:8], a1);
        tw_byte(w[7:0], a2);
        tw_stop();
    endtask

    task automatic check_regs(input string req, input int e0, input int e1, input int e2);
        chk_eq(req, ctl0, e0);
        chk_eq(req, ctl1, e1);
        chk_eq(req, ctl2, e2);
    endtask

    // R1: reset values
    task automatic t_reset(input logic csb_lvl);
        do_reset(csb_lvl);
        check_regs("R1 reset value", 'h003, 'h00A, 'h003);
        chk_eq("R1 soft reset low", soft_rst, 0);
    endtask

    // R3, R4: three-wire writes and field layout
    task automatic t_3w_basic();
        w3_send({16'h0, word(7'd0, 9'h1C5)}, 16);
        check_regs("R4 3w write r0", 'h1C5, 'h00A, 'h003);
        w3_send({16'h0, word(7'd2, 9'h0F0)}, 16);
        check_regs("R3 3w write r2", 'h1C5, 'h00A, 'h0F0);
    endtask

    // R3: only the last 16 bits count
    task automatic t_3w_last16();
        w3_send({12'h0, 4'hF, word(7'd1, 9'h155)}, 20);
        check_regs("R3 last 16 bits", 'h1C5, 'h155, 'h0F0);
    endtask

    // R8: undefined address ignored
    task automatic t_3w_undef();
        w3_send({16'h0, word(7'd5, 9'h1FF)}, 16);
        check_regs("R8 3w undefined addr", 'h1C5, 'h155, 'h0F0);
    endtask

    // R2: two-wire traffic ignored in three-wire mode
    task automatic t_3w_ignores_2w();
        tw_write(8'h34, word(7'd0, 9'h011));
        chk_eq("R2 no ack in 3w mode", a0, 0);
        check_regs("R2 2w traffic ignored", 'h1C5, 'h155, 'h0F0);
    endtask

    // R9: full-length software reset, data ignored
    task automatic t_srst_full();
        srst_hi = 0;
        w3_send({16'h0, word(7'd7, 9'h1AB)}, 16);
        wt(SRST + 50);
        chk_eq("R9 soft reset length", srst_hi, SRST);
        chk_eq("R9 soft reset ended", soft_rst, 0);
        check_regs("R9 regs untouched", 'h1C5, 'h155, 'h0F0);
    endtask

    // R10: early release by next write
    task automatic t_srst_early();
        srst_hi = 0;
        w3_send({16'h0, word(7'd7, 9'h000)}, 16);
        chk_eq("R10 soft reset raised", soft_rst, 1);
        w3_send({16'h0, word(7'd1, 9'h0AA)}, 16);
        chk_eq("R10 released by write", soft_rst, 0);
        chk(srst_hi > 260 && srst_hi < SRST, "R10 early length", srst_hi, 287);
        check_regs("R10 write applied", 'h1C5, 'h0AA, 'h0F0);
    endtask

    // R5, R4: two-wire writes with acknowledge
    task automatic t_2w_write();
        tw_write(8'h34, word(7'd2, 9'h1A5));
        chk_eq("R5 ack device", a0, 1);
        chk_eq("R5 ack byte1", a1, 1);
        chk_eq("R5 ack byte2", a2, 1);
        check_regs("R5 2w write", 'h003, 'h00A, 'h1A5);
        tw_write(8'h34, word(7'd0, 9'h100));
        check_regs("R4 bit8 in first byte", 'h100, 'h00A, 'h1A5);
    endtask

    // R6: wrong identity or read direction
    task automatic t_2w_badaddr();
        tw_write(8'h36, word(7'd1, 9'h077));
        chk_eq("R6 no ack wrong id", a0 | a1 | a2, 0);
        tw_write(8'h35, word(7'd1, 9'h077));
        chk_eq("R6 no ack read bit", a0 | a1 | a2, 0);
        check_regs("R6 no write", 'h100, 'h00A, 'h1A5);
    endtask

    // R7: out-of-sequence stop and start
    task automatic t_2w_abort();
        logic [15:0] w;
        w = word(7'd0, 9'h1FF);
        tw_start();
        tw_byte(8'h34, a0);
        tw_bits(w[15:8], 4);
        tw_stop();
        check_regs("R7 stop aborts", 'h100, 'h00A, 'h1A5);
        tw_start();
        tw_byte(8'h34, a0);
        tw_byte(w[15:8], a1);
        tw_bits(w[7:0], 3);
        tw_write(8'h34, word(7'd1, 9'h0C3));
        chk_eq("R7 restart acked", a2, 1);
        check_regs("R7 start aborts then restarts", 'h100, 'h0C3, 'h1A5);
    endtask

    // R8: undefined address acked and ignored
    task automatic t_2w_undef();
        tw_write(8'h34, word(7'd6, 9'h1FF));
        chk_eq("R8 undefined acked", a0 & a1 & a2, 1);
        check_regs("R8 2w undefined addr", 'h100, 'h0C3, 'h1A5);
    endtask

    // R2: three-wire frames ignored in two-wire mode
    task automatic t_2w_ignores_3w();
        w3_send({16'h0, word(7'd0, 9'h0FF)}, 16);
        check_regs("R2 3w traffic ignored", 'h100, 'h0C3, 'h1A5);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset(1'b1);
        t_3w_basic();
        t_3w_last16();
        t_3w_undef();
        t_3w_ignores_2w();
        t_srst_full();
        t_srst_early();
        t_reset(1'b0);
        t_2w_write();
        t_2w_badaddr();
        t_2w_abort();
        t_2w_undef();
        t_2w_ignores_3w();
        finish_run();
    end
endmodule